// File: doc/BRIEF.md
# Mains-Synchronous Cycle Length Tuner

This block keeps an accelerator's cycle starts in step with the 50 Hz mains. It watches two kinds of timestamped timing events. The first marks a rising zero crossing of the mains, with a resolution of 1 us. The second announces a cycle start and carries that cycle's deadline and its length in nanoseconds. From the most recent `N_WIN` mains edges it fits a least-squares straight line and predicts the mains edge after next. It then works out how long the next cycle must be for the cycle after it to begin on that predicted edge.

The computed length is limited to a safe band and packed into a tune message. The message carries a fixed group ID and event number, a 64-bit parameter with the length in its low 32 bits, and a deadline 1 ms after the mains edge that triggered it. A downstream sender takes the message through a valid/ready handshake. While a calculation is running, the block raises `busy`.

The window is a circular store of timestamps. When a calculation starts, the samples are swept oldest first to build the regression sums, each sample taken relative to the oldest one. A single signed division by a constant denominator then yields the prediction. The block assumes that mains edges are at least `N_WIN + 2` clock cycles apart, which holds by many orders of magnitude for a 20 ms period.

Top module: `mains_cycle_tuner`

## Requirements
- R1: While reset is asserted and right after it, `tune_valid` and `busy` are 0.
- R2: No tune message is produced before `N_WIN` mains edges have been recorded since reset.
- R3: A calculation starts only after at least one new mains edge and at least one new cycle-start event since the previous start, in either order. It starts on the cycle after the later of the two is sampled. A mains edge alone, or a cycle start alone, produces nothing.
- R4: Let y_i be timestamp i minus the oldest timestamp in the window, for i = 0..N-1 with 0 the oldest. Let Sy = sum of y_i, Sxy = sum of i*y_i, Sx = N(N-1)/2, Sxx = (N-1)N(2N-1)/6 and D = N*Sxx - Sx^2. The predicted edge is the oldest timestamp plus (2*D*Sy + N(N+3)*(N*Sxy - Sx*Sy)) / (2*N*D), truncated toward zero. Only the last `N_WIN` edges take part.
- R5: The length is the predicted edge minus (cycle-start deadline + carried cycle length). It is limited to the range 19,800,000 ns to 24,000,000 ns, inclusive.
- R6: The tune message has group ID 0x04C0 on `tune_gid` and event number 0x0FC1 on `tune_evt`. Its deadline is the newest mains timestamp plus 1,000,000 ns. `tune_param[31:0]` holds the length and `tune_param[63:32]` is zero.
- R7: Once `tune_valid` is high, it stays high with all fields unchanged until a cycle in which `tune_ready` is high. It drops on the following cycle.
- R8: `busy` is high from the cycle after the start until the result appears, and never while `tune_valid` is high. The result appears N_WIN + ACC_W + 5 cycles after the edge that samples the later starting event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_valid | input | 1 | Mains rising-edge event present |
| trig_ts | input | 64 | Mains edge timestamp, ns |
| cyc_valid | input | 1 | Cycle-start event present |
| cyc_deadline | input | 64 | Deadline of the current cycle start, ns |
| cyc_len | input | 32 | Length of the current cycle, ns |
| tune_valid | output | 1 | Tune message available |
| tune_ready | input | 1 | Downstream accepts the tune message |
| tune_deadline | output | 64 | Tune message deadline, ns |
| tune_gid | output | 16 | Tune message group ID |
| tune_evt | output | 16 | Tune message event number |
| tune_param | output | 64 | Tune message parameter, length in the low 32 bits |
| busy | output | 1 | Calculation in progress |

## Verification
A tune message is due exactly N_WIN + ACC_W + 5 clock edges after the edge that samples the later of the mains edge and the cycle-start event, which is 126 edges with the default parameters. The bench drives each event just after a rising edge, then counts edges and samples the outputs 1 ns after each one. It requires the first `tune_valid` to appear at exactly that count and checks `busy` at a fixed edge in between. For the negative cases (a window not yet full, or only one kind of fresh event), the bench polls `tune_valid` at every edge for well over one full latency before the missing event arrives.

// File: rtl/mct_pkg.sv
package mct_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SWEEP,
      ST_MUL,
      ST_DIVS,
      ST_DIVW,
      ST_FIN,
      ST_OUT
   } tun_state_e;

   // sum of sample indices 0..n-1
   function automatic longint idx_sum(input longint n);
      return n * (n - 1) / 2;
   endfunction

   // sum of squared sample indices 0..n-1
   function automatic longint idx_sq_sum(input longint n);
      return (n - 1) * n * (2 * n - 1) / 6;
   endfunction

   // fixed regression denominator term n*Sxx - Sx^2
   function automatic longint fit_det(input longint n);
      return n * idx_sq_sum(n) - idx_sum(n) * idx_sum(n);
   endfunction

endpackage

// File: rtl/mct_trig_window.sv
module mct_trig_window #(
   parameter int N_WIN = 25,
   parameter int TS_W  = 64,
   localparam int IDX_W = $clog2(N_WIN),
   localparam int CNT_W = $clog2(N_WIN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TS_W-1:0]  wr_data,
   input  logic [IDX_W-1:0] rd_base,
   input  logic [IDX_W-1:0] rd_ofs,
   output logic [TS_W-1:0]  rd_data,
   output logic [IDX_W-1:0] wr_ptr,
   output logic             full
);

   logic [N_WIN-1:0][TS_W-1:0] slot_flat;
   logic [IDX_W:0]             idx_sum;
   logic [IDX_W:0]             idx_wrap;
   logic [CNT_W-1:0]           fill_q;

   for (genvar i = 0; i < N_WIN; i++) begin : g_slot
      logic [TS_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_ptr == IDX_W'(i)))
            q <= wr_data;
      end
      assign slot_flat[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         fill_q <= '0;
      end else if (wr_en) begin
         wr_ptr <= (wr_ptr == IDX_W'(N_WIN - 1)) ? '0 : wr_ptr + 1'b1;
         if (fill_q != CNT_W'(N_WIN))
            fill_q <= fill_q + 1'b1;
      end
   end

   assign full     = (fill_q == CNT_W'(N_WIN));
   assign idx_sum  = {1'b0, rd_base} + {1'b0, rd_ofs};
   assign idx_wrap = (idx_sum >= (IDX_W + 1)'(N_WIN)) ? idx_sum - (IDX_W + 1)'(N_WIN) : idx_sum;
   assign rd_data  = slot_flat[idx_wrap[IDX_W-1:0]];

endmodule

// File: rtl/mct_seq_div.sv
module mct_seq_div #(
   parameter int W = 96,
   localparam int CW = $clog2(W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic signed [W-1:0] dividend,
   input  logic [W-1:0]        divisor,
   output logic                done,
   output logic signed [W-1:0] quotient
);

   logic [W-1:0]  mag_q;
   logic [W-1:0]  rem_q;
   logic          neg_q;
   logic [CW-1:0] cnt_q;
   logic [W:0]    rem_sh;
   logic [W:0]    rem_nx;
   logic          take;

   assign rem_sh = {rem_q, mag_q[W-1]};
   assign take   = (rem_sh >= {1'b0, divisor});
   assign rem_nx = take ? rem_sh - {1'b0, divisor} : rem_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q <= '0;
         rem_q <= '0;
         neg_q <= 1'b0;
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (start) begin
         neg_q <= dividend[W-1];
         mag_q <= dividend[W-1] ? W'(-dividend) : W'(dividend);
         rem_q <= '0;
         cnt_q <= CW'(W);
         done  <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q <= rem_nx[W-1:0];
         mag_q <= {mag_q[W-2:0], take};
         cnt_q <= cnt_q - 1'b1;
         done  <= (cnt_q == CW'(1));
      end else begin
         done  <= 1'b0;
      end
   end

   assign quotient = neg_q ? -$signed(mag_q) : $signed(mag_q);

endmodule

// File: rtl/mains_cycle_tuner.sv
module mains_cycle_tuner
   import mct_pkg::*;
#(
   parameter int              N_WIN        = 25,
   parameter int              TS_W         = 64,
   parameter int              LEN_W        = 32,
   parameter int              PARAM_W      = 64,
   parameter int              ACC_W        = 96,
   parameter int              ID_W         = 16,
   parameter longint          MIN_LEN_NS   = 19_800_000,
   parameter longint          MAX_LEN_NS   = 24_000_000,
   parameter longint          TUNE_OFS_NS  = 1_000_000,
   parameter logic [ID_W-1:0] TUNE_GID     = 16'h04C0,
   parameter logic [ID_W-1:0] TUNE_EVT     = 16'h0FC1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_valid,
   input  logic [TS_W-1:0]    trig_ts,
   input  logic               cyc_valid,
   input  logic [TS_W-1:0]    cyc_deadline,
   input  logic [LEN_W-1:0]   cyc_len,
   output logic               tune_valid,
   input  logic               tune_ready,
   output logic [TS_W-1:0]    tune_deadline,
   output logic [ID_W-1:0]    tune_gid,
   output logic [ID_W-1:0]    tune_evt,
   output logic [PARAM_W-1:0] tune_param,
   output logic               busy
);

   localparam int     IDX_W = $clog2(N_WIN);
   localparam longint SX    = idx_sum(longint'(N_WIN));
   localparam longint DFIX  = fit_det(longint'(N_WIN));
   localparam longint C_XY  = longint'(N_WIN) * N_WIN * (N_WIN + 3);
   localparam longint C_Y   = 2 * DFIX - longint'(N_WIN) * (N_WIN + 3) * SX;
   localparam longint DEN   = 2 * longint'(N_WIN) * DFIX;

   localparam logic signed [ACC_W-1:0] C_XY_S  = ACC_W'(C_XY);
   localparam logic signed [ACC_W-1:0] C_Y_S   = ACC_W'(C_Y);
   localparam logic [ACC_W-1:0]        DEN_U   = ACC_W'(DEN);
   localparam logic signed [ACC_W-1:0] MIN_S   = ACC_W'(MIN_LEN_NS);
   localparam logic signed [ACC_W-1:0] MAX_S   = ACC_W'(MAX_LEN_NS);
   localparam logic [LEN_W-1:0]        MIN_L   = LEN_W'(MIN_LEN_NS);
   localparam logic [LEN_W-1:0]        MAX_L   = LEN_W'(MAX_LEN_NS);
   localparam logic [TS_W-1:0]         OFS_T   = TS_W'(TUNE_OFS_NS);

   // elaboration-time parameter checks
   if (N_WIN < 3) begin : g_chk_n
      $error("mains_cycle_tuner: N_WIN must be at least 3");
   end
   if (ACC_W <= TS_W) begin : g_chk_acc
      $error("mains_cycle_tuner: ACC_W must exceed TS_W");
   end
   if (PARAM_W < LEN_W) begin : g_chk_param
      $error("mains_cycle_tuner: PARAM_W must hold LEN_W");
   end
   if (MIN_LEN_NS > MAX_LEN_NS || (MAX_LEN_NS >> LEN_W) != 0) begin : g_chk_lim
      $error("mains_cycle_tuner: length limits out of order or too wide");
   end

   tun_state_e               state_q;
   logic [IDX_W-1:0]         k_q;
   logic [IDX_W-1:0]         base_q;
   logic [IDX_W-1:0]         wr_ptr;
   logic                     win_full;
   logic [TS_W-1:0]          rd_data;
   logic [TS_W-1:0]          ts0_q;
   logic [TS_W-1:0]          last_ts_q;
   logic [TS_W-1:0]          cyc_dl_q;
   logic [LEN_W-1:0]         cyc_len_q;
   logic [TS_W-1:0]          snap_dl_q;
   logic [LEN_W-1:0]         snap_len_q;
   logic [TS_W-1:0]          tune_dl_q;
   logic signed [ACC_W-1:0]  sy_q;
   logic signed [ACC_W-1:0]  sxy_q;
   logic signed [ACC_W-1:0]  num_q;
   logic signed [ACC_W-1:0]  quo_q;
   logic signed [ACC_W-1:0]  div_quo;
   logic                     div_done;
   logic                     div_start;
   logic                     trig_new_q;
   logic                     cyc_new_q;
   logic                     start;
   logic                     out_valid_q;
   logic [TS_W-1:0]          out_dl_q;
   logic [LEN_W-1:0]         out_len_q;

   logic [TS_W-1:0]          y_diff;
   logic signed [ACC_W-1:0]  y_ext;
   logic signed [ACC_W-1:0]  k_ext;
   logic signed [ACC_W-1:0]  pred_w;
   logic signed [ACC_W-1:0]  nstart_w;
   logic signed [ACC_W-1:0]  diff_w;
   logic                     below;
   logic                     above;
   logic [LEN_W-1:0]         len_sel;

   mct_trig_window #(
      .N_WIN (N_WIN),
      .TS_W  (TS_W)
   ) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (trig_valid),
      .wr_data (trig_ts),
      .rd_base (base_q),
      .rd_ofs  (k_q),
      .rd_data (rd_data),
      .wr_ptr  (wr_ptr),
      .full    (win_full)
   );

   mct_seq_div #(
      .W (ACC_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (num_q),
      .divisor  (DEN_U),
      .done     (div_done),
      .quotient (div_quo)
   );

   // a trigger landing on the start edge would overwrite the oldest slot
   assign start     = (state_q == ST_IDLE) && win_full && trig_new_q && cyc_new_q && !trig_valid;
   assign div_start = (state_q == ST_DIVS);

   // sample relative to the oldest entry of the snapshot window
   assign y_diff = rd_data - ts0_q;
   assign y_ext  = (k_q == '0) ? '0 : {{(ACC_W - TS_W){y_diff[TS_W-1]}}, y_diff};
   assign k_ext  = {{(ACC_W - IDX_W){1'b0}}, k_q};

   // length derivation and limiting
   assign pred_w   = {{(ACC_W - TS_W){1'b0}}, ts0_q} + quo_q;
   assign nstart_w = {{(ACC_W - TS_W){1'b0}}, snap_dl_q} + {{(ACC_W - LEN_W){1'b0}}, snap_len_q};
   assign diff_w   = pred_w - nstart_w;
   assign below    = diff_w < MIN_S;
   assign above    = diff_w > MAX_S;
   assign len_sel  = below ? MIN_L : (above ? MAX_L : diff_w[LEN_W-1:0]);

   // latest event data and freshness flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ts_q  <= '0;
         cyc_dl_q   <= '0;
         cyc_len_q  <= '0;
         trig_new_q <= 1'b0;
         cyc_new_q  <= 1'b0;
      end else begin
         if (trig_valid)
            last_ts_q <= trig_ts;
         if (cyc_valid) begin
            cyc_dl_q  <= cyc_deadline;
            cyc_len_q <= cyc_len;
         end
         trig_new_q <= trig_valid | (trig_new_q & ~start);
         cyc_new_q  <= cyc_valid  | (cyc_new_q  & ~start);
      end
   end

   // calculation sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         k_q         <= '0;
         base_q      <= '0;
         ts0_q       <= '0;
         snap_dl_q   <= '0;
         snap_len_q  <= '0;
         tune_dl_q   <= '0;
         sy_q        <= '0;
         sxy_q       <= '0;
         num_q       <= '0;
         quo_q       <= '0;
         out_valid_q <= 1'b0;
         out_dl_q    <= '0;
         out_len_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q     <= wr_ptr;
                  snap_dl_q  <= cyc_dl_q;
                  snap_len_q <= cyc_len_q;
                  tune_dl_q  <= last_ts_q + OFS_T;
                  k_q        <= '0;
                  state_q    <= ST_SWEEP;
               end
            end
            ST_SWEEP: begin
               if (k_q == '0) begin
                  ts0_q <= rd_data;
                  sy_q  <= '0;
                  sxy_q <= '0;
               end else begin
                  sy_q  <= sy_q + y_ext;
                  sxy_q <= sxy_q + k_ext * y_ext;
               end
               if (k_q == IDX_W'(N_WIN - 1)) begin
                  k_q     <= '0;
                  state_q <= ST_MUL;
               end else begin
                  k_q <= k_q + 1'b1;
               end
            end
            ST_MUL: begin
               num_q   <= C_XY_S * sxy_q + C_Y_S * sy_q;
               state_q <= ST_DIVS;
            end
            ST_DIVS: begin
               state_q <= ST_DIVW;
            end
            ST_DIVW: begin
               if (div_done) begin
                  quo_q   <= div_quo;
                  state_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               out_len_q   <= len_sel;
               out_dl_q    <= tune_dl_q;
               out_valid_q <= 1'b1;
               state_q     <= ST_OUT;
            end
            ST_OUT: begin
               if (tune_ready) begin
                  out_valid_q <= 1'b0;
                  state_q     <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != ST_IDLE) && (state_q != ST_OUT);
   assign tune_valid    = out_valid_q;
   assign tune_deadline = out_dl_q;
   assign tune_gid      = TUNE_GID;
   assign tune_evt      = TUNE_EVT;
   assign tune_param    = {{(PARAM_W - LEN_W){1'b0}}, out_len_q};

endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
   parameter int              N_WIN      = 25,
   parameter int              TS_W       = 64,
   parameter int              PARAM_W    = 64,
   parameter int              LEN_W      = 32,
   parameter int              ID_W       = 16,
   parameter longint          MIN_LEN_NS = 19_800_000,
   parameter longint          MAX_LEN_NS = 24_000_000,
   parameter logic [ID_W-1:0] TUNE_GID   = 16'h04C0,
   parameter logic [ID_W-1:0] TUNE_EVT   = 16'h0FC1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trig_valid,
   input logic               tune_valid,
   input logic               tune_ready,
   input logic [TS_W-1:0]    tune_deadline,
   input logic [ID_W-1:0]    tune_gid,
   input logic [ID_W-1:0]    tune_evt,
   input logic [PARAM_W-1:0] tune_param,
   input logic               busy
);

   localparam int SC_W = $clog2(N_WIN + 1);

   logic [SC_W-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (trig_valid && seen_q != SC_W'(N_WIN))
         seen_q <= seen_q + 1'b1;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !tune_valid && !busy)
      else $error("reset_idle_chk");

   // R2
   fill_before_tune_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tune_valid |-> seen_q == SC_W'(N_WIN))
      else $error("fill_before_tune_chk");

   // R5
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tune_valid |-> (64'(tune_param[LEN_W-1:0]) >= 64'(MIN_LEN_NS)) &&
                     (64'(tune_param[LEN_W-1:0]) <= 64'(MAX_LEN_NS)))
      else $error("len_range_chk");

   // R6
   msg_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tune_valid |-> tune_gid == TUNE_GID && tune_evt == TUNE_EVT &&
                     tune_param[PARAM_W-1:LEN_W] == '0)
      else $error("msg_tag_chk");

   // R7
   hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tune_valid && !tune_ready |=> tune_valid && $stable(tune_deadline) && $stable(tune_param))
      else $error("hold_until_ready_chk");

   // R7
   drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tune_valid && tune_ready |=> !tune_valid)
      else $error("drop_after_take_chk");

   // R8
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && tune_valid))
      else $error("busy_excl_chk");

endmodule

bind mains_cycle_tuner mct_checker #(
   .N_WIN      (N_WIN),
   .TS_W       (TS_W),
   .PARAM_W    (PARAM_W),
   .LEN_W      (LEN_W),
   .ID_W       (ID_W),
   .MIN_LEN_NS (MIN_LEN_NS),
   .MAX_LEN_NS (MAX_LEN_NS),
   .TUNE_GID   (TUNE_GID),
   .TUNE_EVT   (TUNE_EVT)
) u_mct_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .trig_valid    (trig_valid),
   .tune_valid    (tune_valid),
   .tune_ready    (tune_ready),
   .tune_deadline (tune_deadline),
   .tune_gid      (tune_gid),
   .tune_evt      (tune_evt),
   .tune_param    (tune_param),
   .busy          (busy)
);

// File: tb/test_mains_cycle_tuner.sv
`timescale 1ns/1ps
module test_mains_cycle_tuner;

   localparam int     NW    = 25;
   localparam int     AW    = 96;
   localparam int     LAT   = NW + AW + 5;
   localparam longint PER   = 20_000_000;
   localparam longint T0    = 64'd5_000_000_000;
   localparam longint LMIN  = 19_800_000;
   localparam longint LMAX  = 24_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_valid = 1'b0;
   logic [63:0] trig_ts = '0;
   logic        cyc_valid = 1'b0;
   logic [63:0] cyc_deadline = '0;
   logic [31:0] cyc_len = '0;
   logic        tune_valid;
   logic        tune_ready = 1'b1;
   logic [63:0] tune_deadline;
   logic [15:0] tune_gid;
   logic [15:0] tune_evt;
   logic [63:0] tune_param;
   logic        busy;

   int     n_tests = 0;
   int     n_fail  = 0;
   longint hist [0:255];
   int     hcount  = 0;
   longint last_ts = 0;

   int          got_lat;
   logic        got;
   logic        busy_mid;
   logic [63:0] cap_dl;
   logic [63:0] cap_param;
   logic [15:0] cap_gid;
   logic [15:0] cap_evt;
   logic        cap_busy;

   always #2.5 clk = ~clk;

   mains_cycle_tuner i_mains_cycle_tuner (
      .clk           (clk),
      .rst_n         (rst_n),
      .trig_valid    (trig_valid),
      .trig_ts       (trig_ts),
      .cyc_valid     (cyc_valid),
      .cyc_deadline  (cyc_deadline),
      .cyc_len       (cyc_len),
      .tune_valid    (tune_valid),
      .tune_ready    (tune_ready),
      .tune_deadline (tune_deadline),
      .tune_gid      (tune_gid),
      .tune_evt      (tune_evt),
      .tune_param    (tune_param),
      .busy          (busy)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected length from the last NW recorded edges
   function automatic longint exp_len(input longint cdl, input longint clen);
      longint base, sy, sxy, y, sx, sxx, dd, num, q, pred, d;
      base = hist[hcount - NW];
      sy = 0;
      sxy = 0;
      for (int i = 0; i < NW; i++) begin
         y   = hist[hcount - NW + i] - base;
         sy  += y;
         sxy += longint'(i) * y;
      end
      sx   = longint'(NW) * (NW - 1) / 2;
      sxx  = longint'(NW - 1) * NW * (2 * NW - 1) / 6;
      dd   = longint'(NW) * sxx - sx * sx;
      num  = 2 * dd * sy + longint'(NW) * (NW + 3) * (longint'(NW) * sxy - sx * sy);
      q    = num / (2 * longint'(NW) * dd);
      pred = base + q;
      d    = pred - (cdl + clen);
      if (d < LMIN) d = LMIN;
      if (d > LMAX) d = LMAX;
      return d;
   endfunction

   task automatic send_trig(input longint ts);
      @(posedge clk);
      #1;
      trig_valid = 1'b1;
      trig_ts    = ts;
      @(posedge clk);
      #1;
      trig_valid = 1'b0;
      hist[hcount] = ts;
      hcount++;
      last_ts = ts;
   endtask

   task automatic send_cyc(input longint dl, input longint len);
      @(posedge clk);
      #1;
      cyc_valid    = 1'b1;
      cyc_deadline = dl;
      cyc_len      = 32'(len);
      @(posedge clk);
      #1;
      cyc_valid = 1'b0;
   endtask

   // count edges from the sampling edge until tune_valid, sampling 1 ns after each edge
   task automatic await_tune();
      got      = 1'b0;
      got_lat  = 0;
      busy_mid = 1'b0;
      for (int c = 1; c <= 400 && !got; c++) begin
         @(posedge clk);
         #1;
         if (c == 10) busy_mid = busy;
         if (tune_valid) begin
            got       = 1'b1;
            got_lat   = c;
            cap_dl    = tune_deadline;
            cap_param = tune_param;
            cap_gid   = tune_gid;
            cap_evt   = tune_evt;
            cap_busy  = busy;
         end
      end
   endtask

   task automatic watch_quiet(input int cycles, input string req);
      logic seen = 1'b0;
      for (int c = 0; c < cycles; c++) begin
         @(posedge clk);
         #1;
         if (tune_valid) seen = 1'b1;
      end
      chk(!seen, req, longint'(seen), 0);
   endtask

   task automatic check_tune(input string tag, input longint exp_dl, input longint exp_l);
      chk(got == 1'b1, {tag, " R3 tune produced"}, longint'(got), 1);
      chk(got_lat == LAT, {tag, " R8 latency"}, got_lat, LAT);
      chk(busy_mid == 1'b1, {tag, " R8 busy during calc"}, longint'(busy_mid), 1);
      chk(cap_busy == 1'b0, {tag, " R8 busy low with result"}, longint'(cap_busy), 0);
      chk(cap_dl == exp_dl, {tag, " R6 deadline"}, cap_dl, exp_dl);
      chk(cap_gid == 16'h04C0 && cap_evt == 16'h0FC1, {tag, " R6 gid/evt"},
          longint'({cap_gid, cap_evt}), longint'({16'h04C0, 16'h0FC1}));
      chk(cap_param[63:32] == 32'h0, {tag, " R6 param upper"}, longint'(cap_param[63:32]), 0);
      chk(longint'(cap_param[31:0]) == exp_l, {tag, " R4/R5 length"}, longint'(cap_param[31:0]), exp_l);
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk(tune_valid == 1'b0, "R1 valid in reset", longint'(tune_valid), 0);
      chk(busy == 1'b0, "R1 busy in reset", longint'(busy), 0);
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(tune_valid == 1'b0 && busy == 1'b0, "R1 idle after reset",
          longint'({tune_valid, busy}), 0);
   endtask

   task automatic t_fill();
      send_cyc(T0 + 24 * PER + 400, PER);
      for (int i = 0; i < NW - 1; i++) send_trig(T0 + longint'(i) * PER);
      watch_quiet(2 * LAT, "R2 no tune before window full");
   endtask

   task automatic t_first();
      send_trig(T0 + 24 * PER);
      await_tune();
      check_tune("first", last_ts + 1_000_000, PER - 400);
   endtask

   task automatic t_trig_first();
      send_trig(T0 + 25 * PER);
      watch_quiet(2 * LAT, "R3 trigger alone gives nothing");
      send_cyc(T0 + 25 * PER + 300, PER);
      await_tune();
      check_tune("trig-first", last_ts + 1_000_000, PER - 300);
   endtask

   task automatic t_cyc_first();
      send_cyc(T0 + 26 * PER - 200, PER);
      watch_quiet(2 * LAT, "R3 cycle start alone gives nothing");
      send_trig(T0 + 26 * PER);
      await_tune();
      check_tune("cyc-first", last_ts + 1_000_000, PER + 200);
   endtask

   task automatic t_noise();
      longint ts = last_ts;
      longint e;
      for (int i = 0; i < NW; i++) begin
         ts = ts + PER + longint'(((i * 37) % 11) - 5) * 1000;
         send_trig(ts);
      end
      send_cyc(last_ts + 100, PER);
      e = exp_len(last_ts + 100, PER);
      await_tune();
      check_tune("noise R4 window slide", last_ts + 1_000_000, e);
   endtask

   task automatic t_clamp_lo();
      longint e;
      send_trig(last_ts + PER + 3000);
      send_cyc(last_ts, PER + 600_000);
      e = exp_len(last_ts, PER + 600_000);
      chk(e == LMIN, "R5 bench low limit reached", e, LMIN);
      await_tune();
      check_tune("clamp-lo R5", last_ts + 1_000_000, LMIN);
   endtask

   task automatic t_clamp_hi();
      longint e;
      send_trig(last_ts + PER - 2000);
      send_cyc(last_ts - 5_000_000, PER);
      e = exp_len(last_ts - 5_000_000, PER);
      chk(e == LMAX, "R5 bench high limit reached", e, LMAX);
      await_tune();
      check_tune("clamp-hi R5", last_ts + 1_000_000, LMAX);
   endtask

   task automatic t_backpressure();
      logic        held;
      logic [63:0] p0;
      logic [63:0] d0;
      tune_ready = 1'b0;
      send_trig(last_ts + PER);
      send_cyc(last_ts + 50, PER);
      await_tune();
      chk(got == 1'b1 && got_lat == LAT, "R7 R8 tune under backpressure", got_lat, LAT);
      p0 = tune_param;
      d0 = tune_deadline;
      held = 1'b1;
      for (int c = 0; c < 30; c++) begin
         @(posedge clk);
         #1;
         if (!tune_valid || tune_param != p0 || tune_deadline != d0 || busy) held = 1'b0;
      end
      chk(held, "R7 held stable while not ready", longint'(held), 1);
      tune_ready = 1'b1;
      @(posedge clk);
      #1;
      chk(tune_valid == 1'b0, "R7 drops after transfer", longint'(tune_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_fill();
      t_first();
      t_trig_first();
      t_cyc_first();
      t_noise();
      t_clamp_lo();
      t_clamp_hi();
      t_backpressure();
      repeat (5) @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule